// File: doc/BRIEF.md
# Two-Source Interrupt Request Arbiter

This block sits inside a peripheral module that hosts two interrupt sources: a serial-peripheral (SP) engine and an asynchronous serial (AS) engine. Each source raises a one-cycle set strobe when it needs service. The block latches the strobe into a pending flag, which stays set until that source's own clear strobe arrives. Each source has a programmable priority level. The block compares the levels with each other and with the CPU's current interrupt mask, and presents a single request level to the CPU-side interrupt controller.

When the CPU runs an acknowledge cycle at the presented level, the block takes part in a bus-wide arbitration. It compares its own arbitration ID with the strongest competing ID on the bus. If it wins, it drives the interrupt vector and the byte address of the matching vector table entry. Both sources share one programmed vector number. The least significant bit of that number is replaced by the identity of the winning source, so the CPU can tell which handler to run.

Top module: `irq_pair_arbiter`

## Requirements
- R1: After reset no flag is pending. A set strobe makes its source pending from the next clock edge. The flag stays set until that source's clear strobe. If set and clear arrive in the same cycle, the set wins.
- R2: A source whose programmed level is 0 never contributes a request, even while its flag is pending.
- R3: A pending source counts only if its level is strictly greater than `cpu_mask`. With no source counting, `irq_level` is 0.
- R4: When both sources count at different levels, `irq_level` shows the higher level. The lower source stays pending and is presented once the higher one is cleared.
- R5: When both sources count at the same level, the SP source wins.
- R6: The driven vector equals `vec_base` with bit 0 replaced: 1 when the SP source wins, 0 when the AS source wins.
- R7: `resp` is 1 only when all of these hold: `iack` is high, `iack_level` equals a nonzero `irq_level`, and `arb_id` is strictly greater than `rival_id`. While `resp` is 0, `vec_out` and `vec_addr` are 0.
- R8: With `arb_id` equal to 0, `resp` is never asserted.
- R9: While `resp` is 1, `vec_addr` equals `vbr` plus four times `vec_out`.
- R10: An acknowledge cycle does not clear a pending flag. The same request is still presented afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lvl_sp | input | 3 | Priority level of the SP source (0 disables it) |
| lvl_as | input | 3 | Priority level of the AS source (0 disables it) |
| vec_base | input | 8 | Shared programmed vector number |
| arb_id | input | 4 | This module's arbitration ID |
| vbr | input | 32 | Vector table base byte address |
| set_sp | input | 1 | SP request strobe |
| set_as | input | 1 | AS request strobe |
| clr_sp | input | 1 | SP pending clear strobe |
| clr_as | input | 1 | AS pending clear strobe |
| cpu_mask | input | 3 | CPU current interrupt mask level |
| iack | input | 1 | Acknowledge cycle in progress |
| iack_level | input | 3 | Level being acknowledged |
| rival_id | input | 4 | Highest competing arbitration ID on the bus |
| irq_level | output | 3 | Presented request level (0 means none) |
| resp | output | 1 | This block won arbitration and drives the vector |
| vec_out | output | 8 | Vector number while responding, else 0 |
| vec_addr | output | 32 | Vector table byte address while responding, else 0 |

## Verification
The only state in the block is the pair of pending flags. A flag that is wrongly set or lost shows up on `irq_level` one clock edge after the strobe that caused it. It shows up as a missing or extra level, or as a lower request that never reappears once the higher one is cleared. A wrong choice of winner at a tie shows up during the acknowledge: the vector LSB and the table address come out wrong in the same cycle. A fault in the ID comparison shows up as `resp` asserted while another module should own the bus.

// File: rtl/irq_pair_pkg.sv
package irq_pair_pkg;
   localparam int N_SRC  = 2;
   localparam int SRC_AS = 0;
   localparam int SRC_SP = 1;
endpackage

// File: rtl/irq_pend_slot.sv
module irq_pend_slot (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic pend_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pend_o <= 1'b0;
      else if (set_i) pend_o <= 1'b1;
      else if (clr_i) pend_o <= 1'b0;
   end

   p_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> pend_o);
   p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !pend_o);
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !clr_i) |=> $stable(pend_o));
endmodule

// File: rtl/irq_level_pick.sv
module irq_level_pick #(
   parameter int LVL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       pend,
   input  logic [LVL_W-1:0] lvl_sp,
   input  logic [LVL_W-1:0] lvl_as,
   input  logic [LVL_W-1:0] cpu_mask,
   output logic [LVL_W-1:0] irq_level,
   output logic             win_sp
);
   import irq_pair_pkg::*;

   logic elig_sp, elig_as;

   always_comb begin
      elig_sp = pend[SRC_SP] && (lvl_sp != '0) && (lvl_sp > cpu_mask);
      elig_as = pend[SRC_AS] && (lvl_as != '0) && (lvl_as > cpu_mask);
      win_sp  = elig_sp && (!elig_as || (lvl_sp >= lvl_as));
      if (win_sp)       irq_level = lvl_sp;
      else if (elig_as) irq_level = lvl_as;
      else              irq_level = '0;
   end

   p_above_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_level != '0) |-> (irq_level > cpu_mask));
   p_tie_sp_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[SRC_SP] && irq_level != '0 && lvl_sp == irq_level) |-> win_sp);
   p_zero_lvl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_sp == '0 && lvl_as == '0) |-> (irq_level == '0));
endmodule

// File: rtl/irq_ack_resp.sv
module irq_ack_resp #(
   parameter int LVL_W  = 3,
   parameter int VEC_W  = 8,
   parameter int ID_W   = 4,
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LVL_W-1:0]  irq_level,
   input  logic              win_sp,
   input  logic              iack,
   input  logic [LVL_W-1:0]  iack_level,
   input  logic [ID_W-1:0]   arb_id,
   input  logic [ID_W-1:0]   rival_id,
   input  logic [VEC_W-1:0]  vec_base,
   input  logic [ADDR_W-1:0] vbr,
   output logic              resp,
   output logic [VEC_W-1:0]  vec_out,
   output logic [ADDR_W-1:0] vec_addr
);
   localparam logic [VEC_W-1:0] LSB_MASK = VEC_W'(1);

   logic [VEC_W-1:0]  vec_num;
   logic [ADDR_W-1:0] offset;

   always_comb begin
      vec_num = (vec_base & ~LSB_MASK) | (win_sp ? LSB_MASK : '0);
      offset  = ADDR_W'(vec_num) << 2;
      resp    = iack && (irq_level != '0) && (iack_level == irq_level)
                && (arb_id != '0) && (arb_id > rival_id);
      vec_out  = resp ? vec_num : '0;
      vec_addr = resp ? (vbr + offset) : '0;
   end

   p_zero_id_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_id == '0) |-> !resp);
   p_base_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
      resp |-> (vec_out[VEC_W-1:1] == vec_base[VEC_W-1:1]));
   p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !resp |-> (vec_out == '0 && vec_addr == '0));
   p_needs_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
      resp |-> (iack && arb_id > rival_id));
endmodule

// File: rtl/irq_pair_arbiter.sv
module irq_pair_arbiter #(
   parameter int LVL_W  = 3,
   parameter int VEC_W  = 8,
   parameter int ID_W   = 4,
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LVL_W-1:0]  lvl_sp,
   input  logic [LVL_W-1:0]  lvl_as,
   input  logic [VEC_W-1:0]  vec_base,
   input  logic [ID_W-1:0]   arb_id,
   input  logic [ADDR_W-1:0] vbr,
   input  logic              set_sp,
   input  logic              set_as,
   input  logic              clr_sp,
   input  logic              clr_as,
   input  logic [LVL_W-1:0]  cpu_mask,
   input  logic              iack,
   input  logic [LVL_W-1:0]  iack_level,
   input  logic [ID_W-1:0]   rival_id,
   output logic [LVL_W-1:0]  irq_level,
   output logic              resp,
   output logic [VEC_W-1:0]  vec_out,
   output logic [ADDR_W-1:0] vec_addr
);
   import irq_pair_pkg::*;

   generate
      if (LVL_W < 1) begin : g_bad_lvl
         $error("LVL_W must be at least 1");
      end
      if (VEC_W < 2) begin : g_bad_vec
         $error("VEC_W must be at least 2");
      end
      if (ID_W < 1) begin : g_bad_id
         $error("ID_W must be at least 1");
      end
      if (ADDR_W < VEC_W + 2) begin : g_bad_addr
         $error("ADDR_W must hold the scaled vector");
      end
   endgenerate

   logic [N_SRC-1:0] set_v, clr_v, pend_v;
   logic             win_sp;

   assign set_v = {set_sp, set_as};
   assign clr_v = {clr_sp, clr_as};

   generate
      for (genvar s = 0; s < N_SRC; s++) begin : g_slot
         irq_pend_slot u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_v[s]),
            .clr_i  (clr_v[s]),
            .pend_o (pend_v[s])
         );
      end
   endgenerate

   irq_level_pick #(.LVL_W(LVL_W)) u_pick (
      .clk       (clk),
      .rst_n     (rst_n),
      .pend      (pend_v),
      .lvl_sp    (lvl_sp),
      .lvl_as    (lvl_as),
      .cpu_mask  (cpu_mask),
      .irq_level (irq_level),
      .win_sp    (win_sp)
   );

   irq_ack_resp #(.LVL_W(LVL_W), .VEC_W(VEC_W), .ID_W(ID_W), .ADDR_W(ADDR_W)) u_ack (
      .clk        (clk),
      .rst_n      (rst_n),
      .irq_level  (irq_level),
      .win_sp     (win_sp),
      .iack       (iack),
      .iack_level (iack_level),
      .arb_id     (arb_id),
      .rival_id   (rival_id),
      .vec_base   (vec_base),
      .vbr        (vbr),
      .resp       (resp),
      .vec_out    (vec_out),
      .vec_addr   (vec_addr)
   );

   p_lower_waits_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_v[SRC_SP] && pend_v[SRC_AS] && lvl_sp > cpu_mask && lvl_as > cpu_mask)
      |-> (irq_level == ((lvl_sp >= lvl_as) ? lvl_sp : lvl_as)));
endmodule

// File: tb/irq_pair_arbiter_test.sv
module irq_pair_arbiter_test;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0]  VBASE = 8'h41;
   localparam logic [31:0] VBR   = 32'h0000_2000;

   // row: {lvl_sp, lvl_as, mask, pend_sp, pend_as, exp_level, exp_sp}
   localparam int NROW = 12;
   localparam logic [14:0] TBL [NROW] = '{
      {3'd5, 3'd3, 3'd0, 1'b1, 1'b1, 3'd5, 1'b1},
      {3'd2, 3'd6, 3'd0, 1'b1, 1'b1, 3'd6, 1'b0},
      {3'd4, 3'd4, 3'd0, 1'b1, 1'b1, 3'd4, 1'b1},
      {3'd0, 3'd3, 3'd0, 1'b1, 1'b1, 3'd3, 1'b0},
      {3'd3, 3'd0, 3'd0, 1'b1, 1'b1, 3'd3, 1'b1},
      {3'd5, 3'd3, 3'd4, 1'b1, 1'b1, 3'd5, 1'b1},
      {3'd5, 3'd3, 3'd5, 1'b1, 1'b1, 3'd0, 1'b0},
      {3'd3, 3'd5, 3'd4, 1'b1, 1'b1, 3'd5, 1'b0},
      {3'd7, 3'd7, 3'd6, 1'b1, 1'b0, 3'd7, 1'b1},
      {3'd7, 3'd2, 3'd7, 1'b0, 1'b1, 3'd0, 1'b0},
      {3'd0, 3'd0, 3'd0, 1'b1, 1'b1, 3'd0, 1'b0},
      {3'd1, 3'd1, 3'd0, 1'b0, 1'b1, 3'd1, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  lvl_sp = '0, lvl_as = '0, cpu_mask = '0, iack_level = '0;
   logic [7:0]  vec_base = VBASE;
   logic [3:0]  arb_id = 4'd5, rival_id = '0;
   logic [31:0] vbr = VBR;
   logic        set_sp = 0, set_as = 0, clr_sp = 0, clr_as = 0, iack = 0;
   logic [2:0]  irq_level;
   logic        resp;
   logic [7:0]  vec_out;
   logic [31:0] vec_addr;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_pair_arbiter uut (
      .clk(clk), .rst_n(rst_n), .lvl_sp(lvl_sp), .lvl_as(lvl_as),
      .vec_base(vec_base), .arb_id(arb_id), .vbr(vbr),
      .set_sp(set_sp), .set_as(set_as), .clr_sp(clr_sp), .clr_as(clr_as),
      .cpu_mask(cpu_mask), .iack(iack), .iack_level(iack_level),
      .rival_id(rival_id), .irq_level(irq_level), .resp(resp),
      .vec_out(vec_out), .vec_addr(vec_addr)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic strobe(input logic ssp, input logic sas, input logic csp, input logic cas);
      @(negedge clk);
      set_sp = ssp; set_as = sas; clr_sp = csp; clr_as = cas;
      @(negedge clk);
      set_sp = 0; set_as = 0; clr_sp = 0; clr_as = 0;
      #1;
   endtask

   task automatic ack_at(input logic [2:0] lvl, input logic [3:0] rival);
      iack = 1; iack_level = lvl; rival_id = rival;
      #1;
   endtask

   task automatic ack_end();
      @(negedge clk);
      iack = 0; iack_level = '0; rival_id = '0;
      #1;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk("R1 reset irq_level", 32'(irq_level), 0);
      chk("R1 reset resp", 32'(resp), 0);
      lvl_sp = 3'd4; lvl_as = 3'd2;
      #1;
      chk("R1 level with nothing in reset", 32'(irq_level), 0);
      @(negedge clk);
      rst_n = 1;

      // table walk
      for (int i = 0; i < NROW; i++) begin
         logic [2:0] el;
         logic       es;
         logic [7:0] ev;
         strobe(0, 0, 1, 1);
         lvl_sp = TBL[i][14:12]; lvl_as = TBL[i][11:9]; cpu_mask = TBL[i][8:6];
         strobe(TBL[i][5], TBL[i][4], 0, 0);
         el = TBL[i][3:1]; es = TBL[i][0];
         ev = {VBASE[7:1], es};
         chk($sformatf("R2 R3 R4 R5 row %0d level", i), 32'(irq_level), 32'(el));
         if (el != 0) begin
            ack_at(el, 4'd0);
            chk($sformatf("R7 row %0d resp", i), 32'(resp), 1);
            chk($sformatf("R5 R6 row %0d vector", i), 32'(vec_out), 32'(ev));
            chk($sformatf("R9 row %0d address", i), vec_addr, VBR + 32'(ev) * 4);
            ack_end();
         end
      end

      // R1: set and clear together, set wins
      strobe(0, 0, 1, 1);
      lvl_sp = 3'd3; lvl_as = 3'd0; cpu_mask = 3'd0;
      strobe(1, 0, 1, 0);
      chk("R1 set beats clear", 32'(irq_level), 3);
      // R10: acknowledge leaves the flag pending
      ack_at(3'd3, 4'd0);
      chk("R10 ack resp", 32'(resp), 1);
      ack_end();
      @(negedge clk); #1;
      chk("R10 still pending after ack", 32'(irq_level), 3);
      strobe(0, 0, 1, 0);
      chk("R1 cleared by strobe", 32'(irq_level), 0);

      // R4: lower level presented after higher cleared
      lvl_sp = 3'd2; lvl_as = 3'd6;
      strobe(1, 1, 0, 0);
      chk("R4 higher first", 32'(irq_level), 6);
      strobe(0, 0, 0, 1);
      chk("R4 lower after clear", 32'(irq_level), 2);

      // R7: arbitration outcomes at level 2 (SP pending)
      ack_at(3'd2, 4'd9);
      chk("R7 rival higher resp", 32'(resp), 0);
      chk("R7 rival higher vec", 32'(vec_out), 0);
      chk("R7 rival higher addr", vec_addr, 0);
      ack_end();
      ack_at(3'd5, 4'd0);
      chk("R7 level mismatch resp", 32'(resp), 0);
      ack_end();
      ack_at(3'd2, 4'd5);
      chk("R7 equal id resp", 32'(resp), 0);
      ack_end();
      ack_at(3'd2, 4'd4);
      chk("R7 rival lower resp", 32'(resp), 1);
      chk("R6 sp lsb", 32'(vec_out), 32'h41);
      ack_end();

      // R8: zero ID never responds
      arb_id = 4'd0;
      ack_at(3'd2, 4'd0);
      chk("R8 zero id resp", 32'(resp), 0);
      chk("R8 zero id vec", 32'(vec_out), 0);
      ack_end();
      arb_id = 4'd5;

      // R1: reset clears pending
      @(negedge clk);
      rst_n = 0;
      #1;
      @(negedge clk);
      rst_n = 1;
      #1;
      chk("R1 reset clears pending", 32'(irq_level), 0);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule